// File: doc/BRIEF.md
# Recirculating Static Serial Shift Register

This block is a 64-stage serial shift register that moves its contents one position toward the output on every rising clock edge. A mode input chooses where the first stage gets its bit. With the mode low, it takes the primary data input. With the mode high, it takes a second serial input. When that second input is wired back to the register's own output, the stored 64-bit word rotates in place. The mode input can also be used to pick between two independent serial sources.

Besides the last-stage output and its complement, the block provides two outputs for chaining units:
- A half-stage output, which copies the last-stage output on each falling edge. It therefore lags the output by half a clock period, so a following unit can sample it safely even when clock edges are slow.
- A cascade clock output, which is a plain copy of the input clock.

The register is fully static. When the clock stops, in either level, the stored contents stay as they are. An active-low asynchronous reset clears every stage and the half stage.

Top module: `recirc_shift_reg`

## Requirements
- R1: While rst_ni is low, all 64 stages and the half stage are 0, so q_o = 0, q_n_o = 1 and q_half_o = 0. After reset is released, q_o stays 0 until the first bit taken in has passed through all the stages.
- R2: A bit taken into stage 1 at rising edge k appears on q_o right after rising edge k+63, and stays there until edge k+64.
- R3: With mode_i = 0, stage 1 takes data_i at each rising edge, and recirc_i has no effect.
- R4: With mode_i = 1, stage 1 takes recirc_i at each rising edge, and data_i has no effect. With recirc_i tied to q_o, a loaded 64-bit word comes back on q_o unchanged after 64 rising edges.
- R5: q_half_o takes the value of q_o at each falling clock edge and keeps it across the rising edge. It therefore equals the previous q_o during the clock-high phase and the current q_o during the clock-low phase.
- R6: q_n_o is always the logical inverse of q_o.
- R7: clk_cas_o follows clk_i combinationally, in both phases.
- R8: While the clock is stopped, high or low, q_o, q_n_o and q_half_o hold their values, whatever data_i, recirc_i and mode_i do.
- R9: A second unit clocked from clk_cas_o and fed from q_half_o (with mode 0) shows on its q_o the first unit's q_o from 64 rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; stages update on the rising edge, the half stage on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low clear of all stages and the half stage |
| mode_i | input | 1 | Source select for stage 1: 0 selects data_i, 1 selects recirc_i |
| data_i | input | 1 | Primary serial input |
| recirc_i | input | 1 | Recirculate or second-source serial input |
| q_o | output | 1 | Last-stage output |
| q_n_o | output | 1 | Inverse of q_o |
| q_half_o | output | 1 | Half-stage output: q_o captured on the falling edge |
| clk_cas_o | output | 1 | Copy of clk_i for driving a following unit |

## Verification
In recirculate mode, two things happen on the same rising edge: the last stage's bit leaves on q_o, and that same bit re-enters stage 1. On that edge the half stage must also keep the old q_o. The bench provokes this by tying recirc_i to q_o after loading a known 64-bit word, then rotating it for two full turns while toggling data_i. It judges the result by requiring the loaded bit order to reappear on q_o every 64 edges. It also requires that q_half_o, sampled during the high phase, still shows the previous q_o. A second unit chained through q_half_o and clk_cas_o runs in every phase of the test and is scored against the first unit's expected stream delayed by 64 edges.

// File: rtl/recirc_pkg.sv
package recirc_pkg;

    // Default number of full stages in the register.
    parameter int unsigned SR_DEPTH = 64;

    // Source that feeds the first stage.
    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_LOOP = 1'b1
    } src_sel_e;

endpackage

// File: rtl/recirc_src_sel.sv
module recirc_src_sel
    import recirc_pkg::*;
(
    input  logic sel_i,
    input  logic data_i,
    input  logic loop_i,
    output logic ser_o
);

    src_sel_e sel;

    always_comb begin
        sel = src_sel_e'(sel_i);
        unique case (sel)
            SRC_LOOP: ser_o = loop_i;
            default:  ser_o = data_i;
        endcase
    end

endmodule

// File: rtl/recirc_shift_chain.sv
module recirc_shift_chain #(
    parameter int unsigned DEPTH = recirc_pkg::SR_DEPTH
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ser_i,
    output logic head_o,
    output logic tail_o
);

    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] stg;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q;

    // Next state: every stage takes its neighbour, stage 1 takes the serial input.
    always_comb begin
        chain_d     = chain_q;
        chain_d.stg = {chain_q.stg[LAST-1:0], ser_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign head_o = chain_q.stg[0];
    assign tail_o = chain_q.stg[LAST];

    // R2: the last stage takes what the stage before it held one edge earlier.
    p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (tail_o == $past(chain_q.stg[LAST-1])))
        else $error("p_shift_step_r2");

endmodule

// File: rtl/recirc_half_stage.sv
module recirc_half_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic q_i,
    output logic half_o
);

    typedef struct packed {
        logic half;
    } half_t;

    half_t half_d;
    half_t half_q;
    logic  armed_q;

    always_comb begin
        half_d      = half_q;
        half_d.half = q_i;
    end

    // Falling-edge capture: lags q_i by half a clock period.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            half_q  <= half_d;
            armed_q <= 1'b1;
        end
    end

    assign half_o = half_q.half;

    // R5: at each falling edge the half stage still holds q from the previous falling edge.
    p_half_lag_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        armed_q |-> (half_o == $past(q_i)))
        else $error("p_half_lag_r5");

endmodule

// File: rtl/recirc_shift_reg.sv
module recirc_shift_reg #(
    parameter int unsigned DEPTH = recirc_pkg::SR_DEPTH
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_i,
    input  logic data_i,
    input  logic recirc_i,
    output logic q_o,
    output logic q_n_o,
    output logic q_half_o,
    output logic clk_cas_o
);

    logic ser_in;
    logic head;
    logic tail;

    recirc_src_sel u_sel (
        .sel_i  (mode_i),
        .data_i (data_i),
        .loop_i (recirc_i),
        .ser_o  (ser_in)
    );

    recirc_shift_chain #(
        .DEPTH (DEPTH)
    ) u_chain (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ser_i  (ser_in),
        .head_o (head),
        .tail_o (tail)
    );

    recirc_half_stage u_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .q_i    (tail),
        .half_o (q_half_o)
    );

    assign q_o       = tail;
    assign q_n_o     = ~tail;
    assign clk_cas_o = clk_i;

    // R3: in data mode stage 1 follows data_i.
    p_sel_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 1'b0) |=> (head == $past(data_i)))
        else $error("p_sel_data_r3");

    // R4: in recirculate mode stage 1 follows recirc_i.
    p_sel_loop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 1'b1) |=> (head == $past(recirc_i)))
        else $error("p_sel_loop_r4");

endmodule

// File: tb/recirc_shift_reg_bench.sv
module recirc_shift_reg_bench;

    localparam int unsigned DEPTH = 64;
    localparam logic [63:0] PATTERN = 64'hC3A5_0F96_1E7B_D248;

    logic clk = 1'b0;
    bit   clk_run = 1'b1;
    logic rst_n;
    logic mode_r, data_r, rec_drv, loop_r;
    logic recirc;
    logic q, q_n, q_half, clk_cas;
    logic q2, q2_n, q2_half, clk_cas2;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic prev_q  = 1'b0;
    logic exp_sb [$];
    logic tail_sb [$];
    logic [15:0] lfsr = 16'hACE1;

    // 250 MHz: 4 ns period; can be stopped in either level.
    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    assign recirc = loop_r ? q : rec_drv;

    recirc_shift_reg #(.DEPTH(DEPTH)) u_recirc_shift_reg (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_r), .data_i(data_r),
        .recirc_i(recirc), .q_o(q), .q_n_o(q_n), .q_half_o(q_half),
        .clk_cas_o(clk_cas)
    );

    recirc_shift_reg #(.DEPTH(DEPTH)) u_recirc_shift_reg_tail (
        .clk_i(clk_cas), .rst_ni(rst_n), .mode_i(1'b0), .data_i(q_half),
        .recirc_i(1'b0), .q_o(q2), .q_n_o(q2_n), .q_half_o(q2_half),
        .clk_cas_o(clk_cas2)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Driver: sets inputs, pushes the bit that stage 1 should take.
    // Monitor: after the edge, pops the expected q and compares.
    task automatic step(input logic mode, input logic dat, input logic rcv, input logic loop);
        logic sel, eq, e2;
        mode_r = mode; data_r = dat; rec_drv = rcv; loop_r = loop;
        sel = mode ? (loop ? prev_q : rcv) : dat;
        exp_sb.push_back(sel);
        @(posedge clk); #1;
        eq = exp_sb.pop_front();
        chk("R2/R3/R4 q", q, eq);
        chk("R6 q_n", q_n, ~eq);
        chk("R5 q_half held over rising edge", q_half, prev_q);
        chk("R7 clk_cas high", clk_cas, 1'b1);
        tail_sb.push_back(eq);
        e2 = tail_sb.pop_front();
        chk("R9 cascaded q", q2, e2);
        prev_q = eq;
        @(negedge clk); #1;
        chk("R5 q_half after falling edge", q_half, eq);
        chk("R7 clk_cas low", clk_cas, 1'b0);
    endtask

    task automatic hold_check(input string lvl);
        logic q_s, qh_s, q2_s;
        q_s = q; qh_s = q_half; q2_s = q2;
        clk_run = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #7;
            mode_r = ~mode_r; data_r = ~data_r; rec_drv = ~rec_drv;
        end
        #10;
        chk({"R8 q held clock ", lvl}, q, q_s);
        chk({"R8 q_n held clock ", lvl}, q_n, ~q_s);
        chk({"R8 q_half held clock ", lvl}, q_half, qh_s);
        chk({"R8 tail unit held clock ", lvl}, q2, q2_s);
        clk_run = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_r = 1'b0; data_r = 1'b1; rec_drv = 1'b1; loop_r = 1'b0;
        for (int i = 0; i < DEPTH - 1; i++) exp_sb.push_back(1'b0);
        for (int i = 0; i < DEPTH; i++) tail_sb.push_back(1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset q", q, 1'b0);
        chk("R1 reset q_n", q_n, 1'b1);
        chk("R1 reset q_half", q_half, 1'b0);
        chk("R1 reset tail unit q", q2, 1'b0);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R1/R2/R3: data mode, random data, recirc_i driven as noise.
        for (int i = 0; i < 80; i++) step(1'b0, rnd(), rnd(), 1'b0);

        // Load the known word through data_i (bit 0 first).
        for (int i = 0; i < DEPTH; i++) step(1'b0, PATTERN[i], ~PATTERN[i], 1'b0);
        chk("R2 first loaded bit on q", q, PATTERN[0]);

        // R4: rotate twice with recirc_i tied to q; data_i toggles as noise.
        for (int j = 1; j <= 2 * DEPTH; j++) begin
            step(1'b1, j[0], 1'b0, 1'b1);
            chk("R4 rotated word order", q, PATTERN[j % DEPTH]);
        end

        // R4: recirc_i as an independent second source.
        for (int i = 0; i < 70; i++) step(1'b1, rnd(), rnd(), 1'b0);

        // R8: stop the clock low, then high.
        hold_check("low");
        step(1'b0, 1'b1, 1'b0, 1'b0);
        mode_r = 1'b0; data_r = 1'b0;
        @(posedge clk); #1;
        begin
            logic eq;
            exp_sb.push_back(1'b0);
            eq = exp_sb.pop_front();
            chk("R2 q before high hold", q, eq);
            tail_sb.push_back(eq);
            chk("R9 tail before high hold", q2, tail_sb.pop_front());
            chk("R5 q_half before high hold", q_half, prev_q);
            hold_check("high");
            @(negedge clk); #1;
            chk("R5 q_half after high hold", q_half, eq);
            prev_q = eq;
        end

        // More traffic in both modes to flush the chain into the tail unit.
        for (int i = 0; i < 140; i++) step(i[3], rnd(), rnd(), 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule